// File: doc/BRIEF.md
# Serial Port Register Access Decoder

This block is the processor-facing front end of a classic eight-register serial port. It decodes a three-wire chip select and captures the select and the three address bits under an active-low address strobe. It accepts read and write strobes of either polarity. Each access is steered to one register of the port's register file. The block drives a selected flag and a driver-disable output for an external bus transceiver.

The block owns only the line format register. The top bit of that register is a bank bit: while it is set, addresses 0 and 1 reach the two bytes of the baud divisor in place of the data and interrupt-enable registers. The other registers live elsewhere. The block takes their contents on per-register read-data inputs. It produces one-hot read and write enable vectors, so that each register can apply its write and its clear-on-read side effects.

All outputs are registered. The strobes, the address and the select are sampled as levels on each rising clock edge. The results appear after that same edge.

Top module: `ser_regif`

## Requirements
- R1: The chip is selected when cs0_i=1, cs1_i=1 and cs2_n_i=0. cs_out_o shows the effective select one cycle after it is sampled.
- R2: While ads_n_i=0 the live select and address are used and captured. While ads_n_i=1 the values captured at the last clock with ads_n_i=0 are used. Holding ads_n_i low gives fully transparent operation.
- R3: A read is active when the chip is selected and either rd_p_i=1 or rd_n_i=0. A write is active when the chip is selected and either wr_p_i=1 or wr_n_i=0.
- R4: With the bank bit at 0, address 0 maps to register id 0 (receive data on read, transmit data on write) and address 1 maps to id 1 (interrupt enable).
- R5: With the bank bit at 1, address 0 maps to id 7 (divisor low byte) and address 1 maps to id 8 (divisor high byte).
- R6: Regardless of the bank bit, addresses 2 to 6 map to ids 2 to 6: interrupt identification, line format, modem control, line status and modem status. Address 7 selects nothing. Ids 2, 5 and 6 are read-only, so a write to them or to address 7 sets no bit of we_o. A read of address 7 sets no bit of re_o and returns 0x00.
- R7: For each access, re_o or we_o has bit [id] set, and rdata_o carries the selected register's data, one cycle after the access is sampled. With no read, rdata_o is 0x00.
- R8: A write to id 3 loads wdata_i into the line format register, which reads back on address 3 and drives lcr_o. Its most significant bit is the bank bit. Reset clears it to 0x00.
- R9: drv_dis_o is 0 in the cycle after a sampled active read, and 1 otherwise.
- R10: When a read and a write are active together, the read is performed and the write is dropped.
- R11: While rst=1 (synchronous, active high), the outputs return to rdata_o=0x00, we_o=0, re_o=0, cs_out_o=0, drv_dis_o=1 and lcr_o=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| cs0_i | input | 1 | Chip select, active high |
| cs1_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Chip select, active low |
| ads_n_i | input | 1 | Address strobe, active low; captures select and address |
| addr_i | input | 3 | Register address |
| rd_p_i | input | 1 | Read strobe, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_p_i | input | 1 | Write strobe, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| wdata_i | input | DATA_W | Write data |
| rbr_i | input | DATA_W | Receive data register contents |
| ier_i | input | DATA_W | Interrupt enable register contents |
| iir_i | input | DATA_W | Interrupt identification contents |
| mcr_i | input | DATA_W | Modem control register contents |
| lsr_i | input | DATA_W | Line status contents |
| msr_i | input | DATA_W | Modem status contents |
| dll_i | input | DATA_W | Divisor low byte contents |
| dlm_i | input | DATA_W | Divisor high byte contents |
| rdata_o | output | DATA_W | Registered read data |
| we_o | output | 9 | One-hot write enables by register id |
| re_o | output | 9 | One-hot read enables by register id |
| lcr_o | output | DATA_W | Line format register |
| cs_out_o | output | 1 | Chip is selected |
| drv_dis_o | output | 1 | Transceiver driver disable, low during reads |

## Verification
Random cycles mix all eight select combinations, both strobe polarities, simultaneous strobes, every address and both banks. This separates a wrong select decode from a wrong polarity merge, and a wrong bank remap from a wrong fixed mapping. Directed sequences change the address while the strobe is high. A correct design uses the captured address, and a design without the capture uses the new one. Other directed sequences flip the bank bit through a write and then read addresses 0 and 1. The rest write to read-only addresses and address 7, so that a dropped write shows as an empty we_o.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_REG = 9;

  typedef enum logic [3:0] {
    RID_DATA = 4'd0,
    RID_IEN  = 4'd1,
    RID_IID  = 4'd2,
    RID_FMT  = 4'd3,
    RID_MCTL = 4'd4,
    RID_LSTS = 4'd5,
    RID_MSTS = 4'd6,
    RID_DIVL = 4'd7,
    RID_DIVH = 4'd8,
    RID_NONE = 4'd15
  } reg_id_e;

  localparam logic [NUM_REG-1:0] WRITABLE = 9'b1_1001_1011;
endpackage

// File: rtl/ser_regif_hold.sv
module ser_regif_hold #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ads_n,
  input  logic          cs_live,
  input  logic [AW-1:0] addr_live,
  output logic          cs_sel,
  output logic [AW-1:0] addr_sel
);
  logic          cs_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      addr_q <= '0;
    end else if (!ads_n) begin
      cs_q   <= cs_live;
      addr_q <= addr_live;
    end
  end

  assign cs_sel   = ads_n ? cs_q   : cs_live;
  assign addr_sel = ads_n ? addr_q : addr_live;
endmodule

// File: rtl/ser_regif_dec.sv
module ser_regif_dec
  import ser_regif_pkg::*;
(
  input  logic              bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_act,
  input  logic              wr_act,
  output reg_id_e           id,
  output logic [NUM_REG-1:0] re_vec,
  output logic [NUM_REG-1:0] we_vec
);
  always_comb begin
    case (addr)
      3'd0:    id = bank ? RID_DIVL : RID_DATA;
      3'd1:    id = bank ? RID_DIVH : RID_IEN;
      3'd2:    id = RID_IID;
      3'd3:    id = RID_FMT;
      3'd4:    id = RID_MCTL;
      3'd5:    id = RID_LSTS;
      3'd6:    id = RID_MSTS;
      default: id = RID_NONE;
    endcase
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_en
    assign re_vec[g] = rd_act && (id == reg_id_e'(4'(g)));
    if (WRITABLE[g]) begin : g_wr
      assign we_vec[g] = wr_act && (id == reg_id_e'(4'(g)));
    end else begin : g_ro
      assign we_vec[g] = 1'b0;
    end
  end
endmodule

// File: rtl/ser_regif_lcr.sv
module ser_regif_lcr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/ser_regif.sv
module ser_regif
  import ser_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs0_i,
  input  logic                cs1_i,
  input  logic                cs2_n_i,
  input  logic                ads_n_i,
  input  logic [2:0]          addr_i,
  input  logic                rd_p_i,
  input  logic                rd_n_i,
  input  logic                wr_p_i,
  input  logic                wr_n_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   rbr_i,
  input  logic [DATA_W-1:0]   ier_i,
  input  logic [DATA_W-1:0]   iir_i,
  input  logic [DATA_W-1:0]   mcr_i,
  input  logic [DATA_W-1:0]   lsr_i,
  input  logic [DATA_W-1:0]   msr_i,
  input  logic [DATA_W-1:0]   dll_i,
  input  logic [DATA_W-1:0]   dlm_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [8:0]          we_o,
  output logic [8:0]          re_o,
  output logic [DATA_W-1:0]   lcr_o,
  output logic                cs_out_o,
  output logic                drv_dis_o
);
  localparam int BANK_BIT = DATA_W - 1;

  logic               cs_live, cs_sel, rd_act, wr_act, fmt_wr;
  logic [ADDR_W-1:0]  addr_sel;
  reg_id_e            id;
  logic [NUM_REG-1:0] re_vec, we_vec;
  logic [DATA_W-1:0]  lcr_q, rd_mux;

  assign cs_live = cs0_i && cs1_i && !cs2_n_i;

  ser_regif_hold #(.AW(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .ads_n(ads_n_i),
    .cs_live(cs_live), .addr_live(addr_i),
    .cs_sel(cs_sel), .addr_sel(addr_sel)
  );

  assign rd_act = cs_sel && (rd_p_i || !rd_n_i);
  assign wr_act = cs_sel && (wr_p_i || !wr_n_i) && !rd_act;

  ser_regif_dec u_dec (
    .bank(lcr_q[BANK_BIT]), .addr(addr_sel),
    .rd_act(rd_act), .wr_act(wr_act),
    .id(id), .re_vec(re_vec), .we_vec(we_vec)
  );

  assign fmt_wr = we_vec[RID_FMT];

  ser_regif_lcr #(.DW(DATA_W)) u_lcr (
    .clk(clk), .rst(rst), .wr(fmt_wr), .wdata(wdata_i), .q(lcr_q)
  );

  always_comb begin
    case (id)
      RID_DATA: rd_mux = rbr_i;
      RID_IEN:  rd_mux = ier_i;
      RID_IID:  rd_mux = iir_i;
      RID_FMT:  rd_mux = lcr_q;
      RID_MCTL: rd_mux = mcr_i;
      RID_LSTS: rd_mux = lsr_i;
      RID_MSTS: rd_mux = msr_i;
      RID_DIVL: rd_mux = dll_i;
      RID_DIVH: rd_mux = dlm_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o   <= '0;
      we_o      <= '0;
      re_o      <= '0;
      cs_out_o  <= 1'b0;
      drv_dis_o <= 1'b1;
    end else begin
      rdata_o   <= rd_act ? rd_mux : '0;
      we_o      <= we_vec;
      re_o      <= re_vec;
      cs_out_o  <= cs_sel;
      drv_dis_o <= !rd_act;
    end
  end

  assign lcr_o = lcr_q;
endmodule

// File: rtl/ser_regif_chk.sv
module ser_regif_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_sel,
  input logic              rd_act,
  input logic              fmt_wr,
  input logic [8:0]        we_o,
  input logic [8:0]        re_o,
  input logic [DATA_W-1:0] lcr_o,
  input logic              cs_out_o,
  input logic              drv_dis_o
);
  // R1
  a_r1_csout_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cs_out_o == $past(cs_sel));
  // R9
  a_r9_ddis_only_reads: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !drv_dis_o) |-> $past(rd_act));
  // R10
  a_r10_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && we_o != 9'd0) |-> !$past(rd_act));
  // R7
  a_r7_onehot_enables: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_o) && $onehot0(re_o) && !(we_o != 9'd0 && re_o != 9'd0));
  // R6
  a_r6_ro_not_written: assert property (@(posedge clk) disable iff (rst)
    !we_o[2] && !we_o[5] && !we_o[6]);
  // R8
  a_r8_lcr_by_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lcr_o != $past(lcr_o)) |-> $past(fmt_wr));
endmodule

bind ser_regif ser_regif_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cs_sel(cs_sel), .rd_act(rd_act), .fmt_wr(fmt_wr),
  .we_o(we_o), .re_o(re_o), .lcr_o(lcr_o), .cs_out_o(cs_out_o),
  .drv_dis_o(drv_dis_o)
);

// File: tb/ser_regif_tb_top.sv
`timescale 1ns/1ps
module ser_regif_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs0, cs1, cs2_n, ads_n, rd_p, rd_n, wr_p, wr_n;
  logic [2:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rv [9];
  logic [DW-1:0] rdata, lcr;
  logic [8:0] we, re;
  logic cs_out, drv_dis;

  int n_vec = 0;
  int n_bad = 0;

  logic m_hcs;
  logic [2:0] m_ha;
  logic [DW-1:0] m_lcr;

  always #4 clk = ~clk;

  ser_regif #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cs0_i(cs0), .cs1_i(cs1), .cs2_n_i(cs2_n),
    .ads_n_i(ads_n), .addr_i(addr), .rd_p_i(rd_p), .rd_n_i(rd_n),
    .wr_p_i(wr_p), .wr_n_i(wr_n), .wdata_i(wdata),
    .rbr_i(rv[0]), .ier_i(rv[1]), .iir_i(rv[2]), .mcr_i(rv[4]),
    .lsr_i(rv[5]), .msr_i(rv[6]), .dll_i(rv[7]), .dlm_i(rv[8]),
    .rdata_o(rdata), .we_o(we), .re_o(re), .lcr_o(lcr),
    .cs_out_o(cs_out), .drv_dis_o(drv_dis)
  );

  function automatic int map_id(logic bank, logic [2:0] a);
    case (a)
      3'd0: return bank ? 7 : 0;
      3'd1: return bank ? 8 : 1;
      3'd7: return -1;
      default: return int'(a);
    endcase
  endfunction

  function automatic logic writable(int id);
    return (id >= 0) && (id != 2) && (id != 5) && (id != 6);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic sc, rd, wr;
    logic [2:0] sa;
    int id;
    logic [DW-1:0] e_rd, e_lcr;
    logic [8:0] e_re, e_we;
    sc = ads_n ? m_hcs : (cs0 && cs1 && !cs2_n);
    sa = ads_n ? m_ha : addr;
    rd = sc && (rd_p || !rd_n);
    wr = sc && (wr_p || !wr_n) && !rd;
    id = map_id(m_lcr[DW-1], sa);
    e_re = (rd && id >= 0) ? 9'(1 << id) : 9'd0;
    e_we = (wr && writable(id)) ? 9'(1 << id) : 9'd0;
    e_rd = 8'h00;
    if (rd && id >= 0) e_rd = (id == 3) ? m_lcr : rv[id];
    e_lcr = (wr && id == 3) ? wdata : m_lcr;
    @(posedge clk);
    if (!ads_n) begin
      m_hcs = cs0 && cs1 && !cs2_n;
      m_ha  = addr;
    end
    m_lcr = e_lcr;
    #2;
    n_vec++;
    check(tag, "rdata", 32'(rdata), 32'(e_rd));
    check(tag, "re", 32'(re), 32'(e_re));
    check(tag, "we", 32'(we), 32'(e_we));
    check(tag, "cs_out", 32'(cs_out), 32'(sc));
    check(tag, "drv_dis", 32'(drv_dis), 32'(!rd));
    check(tag, "lcr", 32'(lcr), 32'(e_lcr));
    @(negedge clk);
  endtask

  task automatic idle();
    cs0 = 1; cs1 = 1; cs2_n = 0; ads_n = 0; addr = 0;
    rd_p = 0; rd_n = 1; wr_p = 0; wr_n = 1; wdata = 0;
  endtask

  task automatic acc(logic r, logic w, logic [2:0] a, logic [DW-1:0] d, string tag);
    idle();
    addr = a; wdata = d; rd_p = r; wr_p = w;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    for (int i = 0; i < 9; i++) rv[i] = 8'(8'h11 * (i + 1) + 8'h03);
    idle();
    m_hcs = 0; m_ha = 0; m_lcr = 0;
    repeat (3) @(negedge clk);
    n_vec++;
    // R11 reset state
    check("R11", "reset", {rdata, we, re, cs_out, drv_dis, lcr},
          {8'h00, 9'd0, 9'd0, 1'b0, 1'b1, 8'h00});
    rst = 0;

    // R4 bank 0 mapping
    acc(1, 0, 3'd0, 8'h00, "R4");
    acc(1, 0, 3'd1, 8'h00, "R4");
    acc(0, 1, 3'd0, 8'h5A, "R4");
    // R8 set bank bit, readback
    acc(0, 1, 3'd3, 8'h83, "R8");
    acc(1, 0, 3'd3, 8'h00, "R8");
    // R5 bank 1 mapping
    acc(1, 0, 3'd0, 8'h00, "R5");
    acc(0, 1, 3'd1, 8'h0C, "R5");
    // R6 read-only and empty address
    acc(0, 1, 3'd2, 8'hFF, "R6");
    acc(0, 1, 3'd5, 8'hFF, "R6");
    acc(0, 1, 3'd7, 8'hFF, "R6");
    acc(1, 0, 3'd7, 8'h00, "R6");
    acc(1, 0, 3'd6, 8'h00, "R6");
    // R10 both strobes: read wins, lcr not written
    acc(1, 1, 3'd3, 8'h00, "R10");
    // R3 active-low strobes
    idle(); addr = 3'd4; rd_n = 0; step("R3");
    idle(); addr = 3'd3; wr_n = 0; wdata = 8'h1B; step("R3");
    // R2 capture then hold while strobe high
    idle(); addr = 3'd4; step("R2");
    idle(); ads_n = 1; addr = 3'd5; rd_p = 1; cs2_n = 1; step("R2");
    // R1 deselect variants
    idle(); cs0 = 0; rd_p = 1; step("R1");
    idle(); cs1 = 0; wr_p = 1; addr = 3'd3; wdata = 8'h80; step("R1");
    idle(); cs2_n = 1; rd_p = 1; step("R1");
    // R9 drive-disable around a read
    acc(0, 0, 3'd1, 8'h00, "R9");
    acc(1, 0, 3'd1, 8'h00, "R9");

    // R7 random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cs0 = (r[2:0] != 0); cs1 = (r[5:3] != 0); cs2_n = (r[8:6] == 0);
      ads_n = (r[11:9] == 0); addr = r[14:12];
      rd_p = (r[16:15] == 0); rd_n = (r[18:17] != 0);
      wr_p = (r[20:19] == 0); wr_n = (r[22:21] != 0);
      wdata = $urandom;
      if (k % 500 == 0) for (int i = 0; i < 9; i++) rv[i] = $urandom;
      step("R7");
    end

    // R8 reset clears line format register
    idle(); rst = 1;
    @(posedge clk); #2;
    m_lcr = 0; m_hcs = 0; m_ha = 0;
    n_vec++;
    check("R8", "lcr_reset", 32'(lcr), 32'h0);
    @(negedge clk); rst = 0;
    acc(1, 0, 3'd0, 8'h00, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule